// File: doc/BRIEF.md
# HI/LO Multiply, Accumulate and Divide Unit

This unit owns a pair of result registers, HI and LO, that together form one double-width accumulator. A start strobe with a three-bit operation code launches a signed or unsigned multiply, multiply-add, multiply-subtract or divide on two operands. All multiply-class operations finish in the edge that accepts them, writing the double-width result with its low half in LO and its high half in HI. Multiply-add and multiply-subtract use the current {HI,LO} pair as the running sum.

Division runs on an iterative shift-subtract engine for one cycle per operand bit. It leaves the quotient in LO and the remainder in HI. While it runs, the unit holds busy high and ignores new start strobes and direct register writes. A zero divisor lets the engine run its full length and then leaves both registers untouched. Software and the surrounding pipeline can also load HI and LO directly through two write ports when the unit is idle.

Top module: `hilo_unit`

## Requirements
- R1: After a synchronous active-low reset, HI, LO and busy are all zero.
- R2: Operation codes 0 (signed multiply) and 1 (unsigned multiply), accepted at an edge where busy is low, write {HI,LO} with the full 64-bit product at that same edge: LO takes bits 31:0 and HI takes bits 63:32. Signed operations sign-extend both operands and unsigned ones zero-extend them. busy stays low.
- R3: Operation codes 2 (signed) and 3 (unsigned) replace {HI,LO} with {HI,LO} plus the product, modulo 2^64, in the accepting edge. Consecutive multiply-adds therefore accumulate.
- R4: Operation codes 4 (signed) and 5 (unsigned) replace {HI,LO} with {HI,LO} minus the product, modulo 2^64, in the accepting edge.
- R5: Operation codes 6 (signed) and 7 (unsigned) divide the first operand by the second. The quotient goes to LO and the remainder to HI. Signed division truncates toward zero, and its remainder takes the sign of the dividend.
- R6: A divide accepted at edge k raises busy after edge k. busy stays high for exactly 32 cycles, and both the fall of busy and the new HI/LO values appear after edge k+32. Before that, HI and LO hold their old values.
- R7: A divide with a zero divisor keeps the same busy timing and leaves HI and LO unchanged.
- R8: Signed division of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0, with the normal latency.
- R9: A start strobe of any operation code while busy is high is ignored. It changes neither the running divide nor HI, LO or busy.
- R10: When busy is low and start is low, hi_we loads hi_wdata into HI and lo_we loads lo_wdata into LO at the next edge, independently of each other. Both writes are ignored while busy is high or when start is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launches the operation in op when the unit is idle |
| op | input | 3 | Operation code (0..7, see requirements) |
| opa | input | 32 | First operand (multiplicand or dividend) |
| opb | input | 32 | Second operand (multiplier or divisor) |
| hi_we | input | 1 | Direct write enable for HI |
| hi_wdata | input | 32 | Data for a direct HI write |
| lo_we | input | 1 | Direct write enable for LO |
| lo_wdata | input | 32 | Data for a direct LO write |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |
| busy | output | 1 | High while a divide is in progress |

## Verification
The bench builds the unit with its default 32-bit width, so the divider runs for 32 cycles. With this width the extreme values are reachable directly: the most negative dividend over minus one, all-ones unsigned operands whose product carries into the top bit of HI, and subtractions that wrap {HI,LO} below zero. A behavioural model compares HI, LO and busy on every cycle. It checks multiply-add chains, mixed random sequences, and starts and writes that arrive during a divide.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  // Operation codes: bit 0 set selects the unsigned variant.
  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_MULU  = 3'd1,
    OP_MADD  = 3'd2,
    OP_MADDU = 3'd3,
    OP_MSUB  = 3'd4,
    OP_MSUBU = 3'd5,
    OP_DIV   = 3'd6,
    OP_DIVU  = 3'd7
  } hilo_op_e;

  function automatic logic op_is_div(input hilo_op_e o);
    return (o == OP_DIV) || (o == OP_DIVU);
  endfunction

  function automatic logic op_is_signed(input hilo_op_e o);
    return ~o[0];
  endfunction

endpackage

// File: rtl/hilo_mac.sv
module hilo_mac
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  hilo_op_e         op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [2*W-1:0]   acc,
  output logic [2*W-1:0]   res
);

  localparam int DW = 2 * W;

  // Widen an operand to double width, sign- or zero-filling the top half.
  function automatic logic [DW-1:0] widen(input logic [W-1:0] x, input logic sgn);
    return {{W{sgn & x[W-1]}}, x};
  endfunction

  // The low 2W bits of a 2W x 2W product equal the exact signed or unsigned product.
  function automatic logic [DW-1:0] product(input logic [W-1:0] x, input logic [W-1:0] y,
                                            input logic sgn);
    logic [DW-1:0] ex;
    logic [DW-1:0] ey;
    ex = widen(x, sgn);
    ey = widen(y, sgn);
    return ex * ey;
  endfunction

  logic [DW-1:0] prod;
  assign prod = product(a, b, op_is_signed(op));

  always_comb begin
    unique case (op)
      OP_MADD, OP_MADDU: res = acc + prod;
      OP_MSUB, OP_MSUBU: res = acc - prod;
      default:           res = prod;
    endcase
  end

endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         sgn,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         last_step,
  output logic         zero_div,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);

  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic          neg_q_q, neg_r_q, zero_q;
  logic [W-1:0]  rem_n, quo_n;

  // Magnitude of a two's complement value; the most negative value maps to 2^(W-1).
  function automatic logic [W-1:0] mag(input logic [W-1:0] x, input logic s);
    return (s && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  // One restoring step: shift in the next dividend bit, subtract when it fits.
  function automatic logic [2*W-1:0] div_step(input logic [W-1:0] r, input logic [W-1:0] q,
                                              input logic [W-1:0] d);
    logic [W:0] sh;
    logic [W:0] diff;
    sh   = {r, q[W-1]};
    diff = sh - {1'b0, d};
    if (!diff[W]) return {diff[W-1:0], q[W-2:0], 1'b1};
    else          return {sh[W-1:0],   q[W-2:0], 1'b0};
  endfunction

  assign {rem_n, quo_n} = div_step(rem_q, quo_q, dvs_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (load) begin
      cnt_q   <= CW'(W);
      rem_q   <= '0;
      quo_q   <= mag(dividend, sgn);
      dvs_q   <= mag(divisor, sgn);
      neg_q_q <= sgn & (dividend[W-1] ^ divisor[W-1]);
      neg_r_q <= sgn & dividend[W-1];
      zero_q  <= (divisor == '0);
    end else if (busy) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy      = (cnt_q != '0);
  assign last_step = (cnt_q == CW'(1));
  assign zero_div  = zero_q;
  assign quot      = neg_q_q ? (~quo_n + 1'b1) : quo_n;
  assign rem       = neg_r_q ? (~rem_n + 1'b1) : rem_n;

  // R9: the engine is never reloaded while an iteration sequence is running.
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R6: once started, the count decreases by exactly one per cycle.
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/hilo_unit.sv
module hilo_unit
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         hi_we,
  input  logic [W-1:0] hi_wdata,
  input  logic         lo_we,
  input  logic [W-1:0] lo_wdata,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         busy
);

  localparam int CW = $clog2(W + 1);

  hilo_op_e      op_e;
  logic          accept, accept_mul, accept_div;
  logic          div_busy, div_last, div_zero;
  logic [W-1:0]  div_q, div_r;
  logic [W-1:0]  hi_q, lo_q;
  logic [2*W-1:0] mac_res;
  logic          div_commit, direct_ok;

  assign op_e       = hilo_op_e'(op);
  assign busy       = div_busy;
  assign accept     = start && !busy;
  assign accept_div = accept && op_is_div(op_e);
  assign accept_mul = accept && !op_is_div(op_e);
  assign div_commit = div_last && !div_zero;
  assign direct_ok  = !busy && !start;

  hilo_mac #(.W(W)) u_mac (
    .op  (op_e),
    .a   (opa),
    .b   (opb),
    .acc ({hi_q, lo_q}),
    .res (mac_res)
  );

  hilo_div #(.W(W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_div),
    .sgn       (op_is_signed(op_e)),
    .dividend  (opa),
    .divisor   (opb),
    .busy      (div_busy),
    .last_step (div_last),
    .zero_div  (div_zero),
    .quot      (div_q),
    .rem       (div_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (accept_mul) begin
      {hi_q, lo_q} <= mac_res;
    end else if (div_commit) begin
      hi_q <= div_r;
      lo_q <= div_q;
    end else if (direct_ok) begin
      if (hi_we) hi_q <= hi_wdata;
      if (lo_we) lo_q <= lo_wdata;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  // Cycle counter for the busy window, kept only for the checks below.
  logic [CW-1:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)    chk_cnt <= '0;
    else if (busy) chk_cnt <= chk_cnt + 1'b1;
    else           chk_cnt <= '0;
  end

  a_r6_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    accept_div |=> busy);

  a_r2_mul_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept_mul |=> !busy);

  a_r6_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (chk_cnt < CW'(W)));

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_cnt == CW'(W)));

  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_last) |=> ($stable(hi_q) && $stable(lo_q)));

  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (div_last && div_zero) |=> ($stable(hi_q) && $stable(lo_q)));

  a_r10_idle_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_ok && hi_we) |=> (hi_q == $past(hi_wdata)));

  a_r10_idle_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_ok && lo_we) |=> (lo_q == $past(lo_wdata)));

endmodule

// File: tb/tb_hilo_unit.sv
module tb_hilo_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_CYCLES = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [31:0] opa, opb, hi_wdata, lo_wdata;
  logic        hi_we, lo_we;
  logic [31:0] hi, lo;
  logic        busy;

  int vectors = 0;
  int fails   = 0;

  // Behavioural model state
  logic [31:0] m_hi = 0, m_lo = 0;
  int          m_left = 0;
  logic [31:0] pend_q, pend_r;
  bit          pend_zero;

  always #(CLK_PERIOD/2) clk = ~clk;

  hilo_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi(hi), .lo(lo), .busy(busy)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
    summary();
    $finish;
  end

  task automatic check(input string tag);
    vectors++;
    if (hi !== m_hi || lo !== m_lo || busy !== (m_left > 0)) begin
      fails++;
      $display("FAIL %s: actual hi=%h lo=%h busy=%b expected hi=%h lo=%h busy=%b",
               tag, hi, lo, busy, m_hi, m_lo, m_left > 0);
    end
  endtask

  // Model of one clock edge given the inputs present at that edge.
  task automatic model_edge(input bit st, input logic [2:0] o, input logic [31:0] a,
                            input logic [31:0] b, input bit hw, input logic [31:0] hd,
                            input bit lw, input logic [31:0] ld);
    logic [63:0] p, acc;
    longint sa, sb;
    int ia, ib;
    bit m_busy;
    m_busy = (m_left > 0);
    if (st && !m_busy) begin
      if (o == 3'd6 || o == 3'd7) begin
        pend_zero = (b == 0);
        if (o == 3'd6) begin
          ia = $signed(a); ib = $signed(b);
          if (b == 0) begin pend_q = 0; pend_r = 0; end
          else if (a == 32'h8000_0000 && ib == -1) begin pend_q = a; pend_r = 0; end
          else begin pend_q = ia / ib; pend_r = ia % ib; end
        end else if (b != 0) begin
          pend_q = a / b; pend_r = a % b;
        end
        m_left = DIV_CYCLES;
      end else begin
        if (o[0]) p = {32'b0, a} * {32'b0, b};
        else begin
          sa = longint'($signed(a)); sb = longint'($signed(b));
          p = 64'(sa * sb);
        end
        acc = {m_hi, m_lo};
        case (o[2:1])
          2'b01:   acc = acc + p;
          2'b10:   acc = acc - p;
          default: acc = p;
        endcase
        {m_hi, m_lo} = acc;
      end
    end else if (m_busy) begin
      m_left--;
      if (m_left == 0 && !pend_zero) begin m_hi = pend_r; m_lo = pend_q; end
    end else begin
      if (hw) m_hi = hd;
      if (lw) m_lo = ld;
    end
  endtask

  // Apply inputs for one cycle (entered at a falling edge), then compare.
  task automatic step(input string tag, input bit st, input logic [2:0] o,
                      input logic [31:0] a, input logic [31:0] b,
                      input bit hw = 0, input logic [31:0] hd = 0,
                      input bit lw = 0, input logic [31:0] ld = 0);
    start = st; op = o; opa = a; opb = b;
    hi_we = hw; hi_wdata = hd; lo_we = lw; lo_wdata = ld;
    @(posedge clk);
    model_edge(st, o, a, b, hw, hd, lw, ld);
    @(negedge clk);
    start = 0; hi_we = 0; lo_we = 0;
    check(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 3'd0, 0, 0);
  endtask

  task automatic run_div(input string tag, input logic [2:0] o, input logic [31:0] a,
                         input logic [31:0] b);
    step(tag, 1, o, a, b);
    while (m_left > 0) idle(tag);
  endtask

  initial begin
    rst_n = 0; start = 0; op = 0; opa = 0; opb = 0;
    hi_we = 0; lo_we = 0; hi_wdata = 0; lo_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    idle("R1 idle after reset");

    // R2: plain products
    step("R2 signed pos*neg", 1, 3'd0, 32'd12345, 32'hFFFF_FFF9);
    step("R2 signed neg*neg", 1, 3'd0, 32'h8000_0000, 32'h8000_0000);
    step("R2 unsigned max*max", 1, 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step("R2 unsigned high bit", 1, 3'd1, 32'h8000_0001, 32'd3);

    // R3: accumulation chains
    step("R3 seed", 1, 3'd0, 32'd0, 32'd0);
    for (int i = 0; i < 5; i++)
      step("R3 signed madd chain", 1, 3'd2, 32'h7FFF_0000 + i, 32'hFFFF_FF00 - i);
    for (int i = 0; i < 4; i++)
      step("R3 unsigned madd carry", 1, 3'd3, 32'hFFFF_FFF0, 32'hF000_0000 + i);

    // R4: subtraction, including wrap below zero
    step("R4 seed", 1, 3'd1, 32'd2, 32'd3);
    step("R4 signed msub", 1, 3'd4, 32'd5, 32'hFFFF_FFFE);
    step("R4 unsigned msub wraps", 1, 3'd5, 32'hFFFF_FFFF, 32'd100);
    step("R4 signed msub neg", 1, 3'd4, 32'h8000_0000, 32'd7);

    // R5 / R6: division and its timing
    run_div("R5 R6 signed 7/-2", 3'd6, 32'd7, 32'hFFFF_FFFE);
    run_div("R5 signed -7/2", 3'd6, 32'hFFFF_FFF9, 32'd2);
    run_div("R5 signed -7/-2", 3'd6, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
    run_div("R5 unsigned max/3", 3'd7, 32'hFFFF_FFFF, 32'd3);
    run_div("R5 unsigned small/large", 3'd7, 32'd5, 32'hFFFF_0000);

    // R7: zero divisor keeps a known pattern
    step("R7 preload", 0, 3'd0, 0, 0, 1, 32'hDEAD_BEEF, 1, 32'h1234_5678);
    run_div("R7 signed zero divisor", 3'd6, 32'd99, 32'd0);
    run_div("R7 unsigned zero divisor", 3'd7, 32'hFFFF_FFFF, 32'd0);

    // R8: most negative over minus one
    run_div("R8 min/-1", 3'd6, 32'h8000_0000, 32'hFFFF_FFFF);

    // R9 / R10: starts and writes during a divide
    step("R9 div start", 1, 3'd7, 32'd1000, 32'd7);
    idle("R9 running");
    step("R9 mult start while busy", 1, 3'd0, 32'd3, 32'd4);
    step("R9 div start while busy", 1, 3'd6, 32'd1, 32'd0);
    step("R10 write while busy", 0, 3'd0, 0, 0, 1, 32'hAAAA_AAAA, 1, 32'h5555_5555);
    while (m_left > 0) idle("R9 R6 drain");

    // R10: idle writes and the start-wins rule
    step("R10 hi only", 0, 3'd0, 0, 0, 1, 32'hCAFE_0001, 0, 32'hFFFF_FFFF);
    step("R10 lo only", 0, 3'd0, 0, 0, 0, 32'hFFFF_FFFF, 1, 32'hCAFE_0002);
    step("R10 write with start", 1, 3'd1, 32'd6, 32'd7, 1, 32'h1111_1111, 1, 32'h2222_2222);
    step("R10 write with div start", 1, 3'd7, 32'd50, 32'd8, 1, 32'h3333_3333, 0, 0);
    while (m_left > 0) idle("R10 R5 drain");

    // Mixed random sequence across every operation code
    for (int i = 0; i < 60; i++) begin
      logic [2:0]  ro;
      logic [31:0] ra, rb;
      ro = 3'($urandom_range(0, 7));
      ra = $urandom();
      rb = (i % 9 == 0) ? 32'd0 : $urandom();
      if (ro >= 3'd6) run_div("R5 mixed divide", ro, ra, rb);
      else step(ro[2] ? "R4 mixed" : (ro[1] ? "R3 mixed" : "R2 mixed"), 1, ro, ra, rb);
    end

    summary();
    $finish;
  end

endmodule